// File: doc/BRIEF.md
# Framed Byte-Stream Link Transmitter

This block turns 104-bit mesh transaction packets into a stream of bytes with a framing strobe, one byte per clock. The clock stands in for a dual-data-rate 8-bit pad interface. A packet is offered on a valid/wait handshake. Once the block takes it, the block raises the frame signal and sends a header of six bytes that it builds from the packet fields, followed by the payload. A 64-bit write that follows a 64-bit write at the next doubleword address is chained onto it: the frame signal stays high and the header of the second packet is not sent.

The far-end receiver can hold off traffic with a wait input whose timing has no fixed relation to the local clock. This input passes through a two-flop synchronizer. When the synchronized wait is high, the block starts no new transaction and does not chain a burst. A transaction that is already being sent runs to its last byte.

Top module: `pktser_tx`

## Requirements
- R1: The packet input fields are placed as follows: access is bit 0, write is bit 1, the size code is bits 3:2 (3 means 64 bits), the control code is bits 7:4, the target address is bits 39:8, the data word is bits 71:40 and the return/upper word is bits 103:72. A packet is taken on a clock edge at which `pkt_valid` is high and `pkt_wait` is low.
- R2: In the cycle after a packet is taken from idle, `lnk_frame` rises and `lnk_data` carries byte 0, which is 8'h00.
- R3: Bytes 1 to 5 are, in order: {control[3:0], addr[31:28]}, addr[27:20], addr[19:12], addr[11:4], and {addr[3:0], size[1:0], write, access}.
- R4: Bytes 6 to 9 carry a 32-bit word, most significant byte first. For a write this is the data word; for a read it is the return word. Any packet that is not a 64-bit write ends at byte 9.
- R5: A 64-bit write goes on with bytes 10 to 13, which carry the upper word (bits 103:72) most significant byte first. The lower word is sent before the upper word.
- R6: During byte 13 of a 64-bit write, a 64-bit write whose address equals the previous address plus 8 is taken. `lnk_frame` then stays high and byte 13 is followed directly by byte 6 of the new packet.
- R7: When no burst continues, `lnk_frame` is low in the cycle after the last byte, so each new transaction starts on a fresh rising edge. This also applies to a following 64-bit write whose address does not follow on.
- R8: `pkt_wait` is high while a transaction is being sent. The only exception is the last byte of a 64-bit write while a packet that qualifies for a burst is offered.
- R9: `far_wait` takes effect on `pkt_wait` after two clock edges. While the synchronized wait is high, no transaction starts and no burst is chained, but a transaction in flight still completes.
- R10: During reset and whenever no transaction is in flight, `lnk_frame` is 0 and `lnk_data` is 8'h00. After reset `pkt_wait` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | A packet is offered |
| pkt_data | input | 104 | Packet being offered |
| pkt_wait | output | 1 | Packet cannot be taken this cycle |
| far_wait | input | 1 | Hold-off from the far end, asynchronous |
| lnk_data | output | 8 | Byte stream |
| lnk_frame | output | 1 | Frame strobe |

## Verification
Each packet kind is sent on its own from idle: a read, a 32-bit write and an 8-bit write. These show whether the payload comes from the data word or from the return word, and that all of them stop at byte 9. A single 64-bit write and a chain of three 64-bit writes at consecutive addresses show the extra four bytes and the header being skipped. A pair of 64-bit writes with a gap in their addresses, and a 64-bit write followed by a 32-bit write, must each give a frame drop instead of a chain. Back-to-back 32-bit writes check the minimum one-cycle gap. Raising `far_wait` partway through a transfer shows that the transfer in flight finishes while the next one is held off for exactly the synchronized window.

// File: rtl/pktser_pkg.sv
package pktser_pkg;
    localparam int PKT_W  = 104;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;

    // field order from MSB to LSB follows the packet bit layout
    typedef struct packed {
        logic [WORD_W-1:0] upper;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] addr;
        logic [3:0]        ctrl;
        logic [1:0]        size;
        logic              wr;
        logic              acc;
    } mpkt_t;

    localparam logic [1:0]       SIZE_64    = 2'b11;
    localparam logic [IDX_W-1:0] IDX_END32  = 4'd9;
    localparam logic [IDX_W-1:0] IDX_END64  = 4'd13;
    localparam logic [IDX_W-1:0] IDX_RESUME = 4'd6;

    function automatic logic is_wide_write(input mpkt_t p);
        return p.wr && (p.size == SIZE_64);
    endfunction
endpackage

// File: rtl/pktser_sync.sv
module pktser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pktser_pack.sv
module pktser_pack
    import pktser_pkg::*;
(
    input  mpkt_t             pkt,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] byte_o
);
    logic [WORD_W-1:0] low_word;

    always_comb begin
        low_word = pkt.wr ? pkt.word : pkt.upper;
        case (idx)
            4'd0:    byte_o = '0;
            4'd1:    byte_o = {pkt.ctrl, pkt.addr[31:28]};
            4'd2:    byte_o = pkt.addr[27:20];
            4'd3:    byte_o = pkt.addr[19:12];
            4'd4:    byte_o = pkt.addr[11:4];
            4'd5:    byte_o = {pkt.addr[3:0], pkt.size, pkt.wr, pkt.acc};
            4'd6:    byte_o = low_word[31:24];
            4'd7:    byte_o = low_word[23:16];
            4'd8:    byte_o = low_word[15:8];
            4'd9:    byte_o = low_word[7:0];
            4'd10:   byte_o = pkt.upper[31:24];
            4'd11:   byte_o = pkt.upper[23:16];
            4'd12:   byte_o = pkt.upper[15:8];
            4'd13:   byte_o = pkt.upper[7:0];
            default: byte_o = '0;
        endcase
    end
endmodule

// File: rtl/pktser_chain.sv
module pktser_chain
    import pktser_pkg::*;
#(
    parameter int STRIDE = 8
) (
    input  mpkt_t cur,
    input  mpkt_t nxt,
    output logic  ok
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(STRIDE);

    always_comb begin
        ok = is_wide_write(cur) && is_wide_write(nxt) && (nxt.addr == cur.addr + STEP);
    end
endmodule

// File: rtl/pktser_tx.sv
module pktser_tx
    import pktser_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int BURST_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_wait,
    input  logic              far_wait,
    output logic [BYTE_W-1:0] lnk_data,
    output logic              lnk_frame
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        mpkt_t            cur;
    } st_t;

    st_t               st_q, st_d;
    mpkt_t             in_pkt;
    logic              far_wait_s;
    logic              chain_ok;
    logic              at_last;
    logic              take;
    logic [BYTE_W-1:0] byte_sel;

    assign in_pkt = mpkt_t'(pkt_data);

    pktser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (far_wait),
        .sync_o  (far_wait_s)
    );

    pktser_chain #(.STRIDE(BURST_STRIDE)) u_chain (
        .cur (st_q.cur),
        .nxt (in_pkt),
        .ok  (chain_ok)
    );

    pktser_pack u_pack (
        .pkt    (st_q.cur),
        .idx    (st_q.idx),
        .byte_o (byte_sel)
    );

    always_comb begin
        at_last  = st_q.busy &&
                   (st_q.idx == (is_wide_write(st_q.cur) ? IDX_END64 : IDX_END32));
        pkt_wait = far_wait_s || (st_q.busy && !(at_last && pkt_valid && chain_ok));
        take     = pkt_valid && !pkt_wait;
        st_d     = st_q;
        if (take) begin
            st_d.busy = 1'b1;
            st_d.cur  = in_pkt;
            st_d.idx  = st_q.busy ? IDX_RESUME : '0;
        end else if (st_q.busy) begin
            if (at_last) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lnk_frame = st_q.busy;
    assign lnk_data  = st_q.busy ? byte_sel : '0;
endmodule

// File: rtl/pktser_tx_chk.sv
module pktser_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lnk_frame,
    input logic [7:0] lnk_data,
    input logic       far_wait,
    input logic       far_wait_s
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (lnk_frame) run_q <= run_q + 16'd1;
        else                run_q <= '0;
    end

    // R2: first byte of a fresh frame is zero
    p_first_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_frame) |-> (lnk_data == 8'h00));

    // R6 and R7: frame length is 10, 14, or 14 plus whole 8-byte continuations
    p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lnk_frame) |-> ((run_q == 16'd10) ||
                              ((run_q >= 16'd14) && (((run_q - 16'd14) % 16'd8) == 16'd0))));

    // R9: synchronized wait rises only two edges after the raw input
    p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(far_wait_s) |-> $past(far_wait, 2));

    // R9: no fresh frame starts while the synchronized wait is high
    p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        far_wait_s |=> !$rose(lnk_frame));

    // R10: bus is quiet outside a frame
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_frame |-> (lnk_data == 8'h00));
endmodule

bind pktser_tx pktser_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lnk_frame  (lnk_frame),
    .lnk_data   (lnk_data),
    .far_wait   (far_wait),
    .far_wait_s (far_wait_s)
);

// File: tb/sim_pktser_tx.sv
module sim_pktser_tx;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pkt_valid = 1'b0;
    logic [103:0] pkt_data = '0;
    logic         far_wait = 1'b0;
    logic         pkt_wait;
    logic [7:0]   lnk_data;
    logic         lnk_frame;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R10";

    logic [7:0]  exp_q[$];
    bit          s1 = 1'b0, s2 = 1'b0;
    bit          tail64 = 1'b0;
    logic [31:0] tail_addr = '0;

    always #2.5 clk = ~clk;

    pktser_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_wait  (pkt_wait),
        .far_wait  (far_wait),
        .lnk_data  (lnk_data),
        .lnk_frame (lnk_frame)
    );

    // R1 field placement
    function automatic logic [103:0] mk(input logic [3:0] ctrl, input logic [1:0] size,
                                        input logic wr, input logic [31:0] addr,
                                        input logic [31:0] word, input logic [31:0] upper);
        return {upper, word, addr, ctrl, size, wr, 1'b1};
    endfunction

    function automatic bit wide(input logic [103:0] p);
        return p[1] && (p[3:2] == 2'b11);
    endfunction

    function automatic void push_pkt(input logic [103:0] p, input bit cont);
        logic [7:0]  b[14];
        logic [31:0] a  = p[39:8];
        logic [31:0] lo = p[1] ? p[71:40] : p[103:72];
        logic [31:0] hi = p[103:72];
        int          n  = wide(p) ? 14 : 10;
        b[0] = 8'h00;
        b[1] = {p[7:4], a[31:28]};
        for (int k = 0; k < 3; k++) b[2+k] = a[27-8*k -: 8];
        b[5] = {a[3:0], p[3:2], p[1], p[0]};
        for (int k = 0; k < 4; k++) begin
            b[6+k]  = lo[31-8*k -: 8];
            b[10+k] = hi[31-8*k -: 8];
        end
        for (int i = (cont ? 6 : 0); i < n; i++) exp_q.push_back(b[i]);
    endfunction

    function automatic bit model_wait();
        bit chainable;
        chainable = tail64 && pkt_valid && wide(pkt_data) &&
                    (pkt_data[39:8] == tail_addr + 32'd8);
        return s2 || (exp_q.size() > 1) || ((exp_q.size() == 1) && !chainable);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            s1 = 1'b0; s2 = 1'b0; tail64 = 1'b0;
        end else begin
            bit acc, cont;
            acc  = pkt_valid && !model_wait();
            cont = acc && (exp_q.size() == 1);
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            if (acc) begin
                push_pkt(pkt_data, cont);
                tail64    = wide(pkt_data);
                tail_addr = pkt_data[39:8];
            end
            s2 = s1;
            s1 = far_wait;
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit         ef, ew;
            logic [7:0] ed;
            ef = exp_q.size() > 0;
            ed = ef ? exp_q[0] : 8'h00;
            ew = model_wait();
            n_cmp++;
            if (lnk_frame !== ef || lnk_data !== ed || pkt_wait !== ew) begin
                n_bad++;
                $display("FAIL %s t=%0t frame/data/wait actual %0b/%02h/%0b expected %0b/%02h/%0b",
                         tag, $time, lnk_frame, lnk_data, pkt_wait, ef, ed, ew);
            end
        end
    end

    task automatic send(input logic [103:0] p);
        bit w;
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_data  = p;
        forever begin
            #1 w = pkt_wait;
            @(posedge clk);
            if (!w) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        pkt_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        pkt_valid = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        n_cmp++;
        if (lnk_frame !== 1'b0 || lnk_data !== 8'h00) begin
            n_bad++;
            $display("FAIL R10 in reset frame/data actual %0b/%02h expected 0/00", lnk_frame, lnk_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        tag = "R4_read";
        send(mk(4'h5, 2'b10, 1'b0, 32'h1234_5678, 32'hDEAD_BEEF, 32'hCAFE_0123));
        drain();
        tag = "R3_write32";
        send(mk(4'hA, 2'b10, 1'b1, 32'h8765_4321, 32'h0102_0304, 32'hFFFF_0000));
        drain();
        tag = "R2_write8";
        send(mk(4'h0, 2'b00, 1'b1, 32'h0000_0011, 32'h0000_00AB, 32'h0));
        drain();
        tag = "R5_write64";
        send(mk(4'h3, 2'b11, 1'b1, 32'h4000_0000, 32'h1111_2222, 32'h3333_4444));
        drain();
        tag = "R6_burst";
        send(mk(4'h1, 2'b11, 1'b1, 32'h5000_0000, 32'hA0A1_A2A3, 32'hB0B1_B2B3));
        send(mk(4'h1, 2'b11, 1'b1, 32'h5000_0008, 32'hC0C1_C2C3, 32'hD0D1_D2D3));
        send(mk(4'h1, 2'b11, 1'b1, 32'h5000_0010, 32'hE0E1_E2E3, 32'hF0F1_F2F3));
        drain();
        tag = "R7_gap_addr";
        send(mk(4'h2, 2'b11, 1'b1, 32'h6000_0000, 32'h1, 32'h2));
        send(mk(4'h2, 2'b11, 1'b1, 32'h6000_0010, 32'h3, 32'h4));
        drain();
        tag = "R7_wide_then_32";
        send(mk(4'h2, 2'b11, 1'b1, 32'h7000_0000, 32'h5, 32'h6));
        send(mk(4'h2, 2'b10, 1'b1, 32'h7000_0008, 32'h7, 32'h0));
        drain();
        tag = "R8_back_to_back";
        send(mk(4'h4, 2'b10, 1'b1, 32'h0000_1000, 32'h9999_8888, 32'h0));
        send(mk(4'h4, 2'b10, 1'b1, 32'h0000_2000, 32'h7777_6666, 32'h0));
        send(mk(4'h4, 2'b01, 1'b0, 32'h0000_3000, 32'h0, 32'h5555_4444));
        drain();
        tag = "R9_far_wait";
        fork
            begin
                send(mk(4'h6, 2'b10, 1'b1, 32'h0ABC_DEF0, 32'h1357_9BDF, 32'h0));
                send(mk(4'h6, 2'b10, 1'b1, 32'h0ABC_DEF4, 32'h2468_ACE0, 32'h0));
            end
            begin
                repeat (3) @(negedge clk);
                far_wait = 1'b1;
                repeat (25) @(negedge clk);
                far_wait = 1'b0;
            end
        join
        drain();
        tag = "R9_wait_in_burst";
        fork
            begin
                send(mk(4'h7, 2'b11, 1'b1, 32'h9000_0000, 32'h1, 32'h2));
                send(mk(4'h7, 2'b11, 1'b1, 32'h9000_0008, 32'h3, 32'h4));
            end
            begin
                repeat (5) @(negedge clk);
                far_wait = 1'b1;
                repeat (20) @(negedge clk);
                far_wait = 1'b0;
            end
        join
        drain();
        tag = "R10_idle";
        idle(5);
        finish_run();
    end
endmodule